// File: doc/BRIEF.md
# Dual-Slope Converter Phase Sequencer

This block is the digital timing engine for an external dual-slope integrating converter. It steps the converter through its four conversion phases by driving a two-bit phase code, watches the converter's zero-crossing comparator, and counts system ticks. The tick rate is the input clock divided by a fixed ratio. The host programs a preload byte that sets how long the auto-zero and integrate phases run. Each of these two phases lasts a multiple of 256 ticks. The de-integrate phase runs until the comparator swings low, and its length in ticks becomes the conversion result.

After each de-integrate phase the block latches three things: the count, an overrange flag and a polarity flag. It then passes through integrator-zero and returns to auto-zero. The active-low data-valid output is low for the whole time the block sits in auto-zero, so a host can poll it or use it as an interrupt. By the time it falls, the newest result is already latched.

A level input holds the sequencer in auto-zero for as long as it is high. A rising edge on the active-low load strobe captures a new preload byte and restarts the sequence. After reset the sequencer waits in integrator-zero until one of these two inputs moves it into auto-zero.

Top module: `dss_phase_seq`

## Requirements
- R1: The phase code on `phase_o` is 2'b01 for auto-zero, 2'b10 for integrate, 2'b11 for de-integrate and 2'b00 for integrator-zero.
- R2: Without an override, phases advance only in the order auto-zero, integrate, de-integrate, integrator-zero, then auto-zero again.
- R3: Unforced phase changes happen only on a system tick, which occurs once every DIV clocks (DIV = 4 by default).
- R4: A full auto-zero and every integrate phase each last (2^PRE_W - P) * 2^LOW_W ticks, where P is the active preload byte. With the default widths, P = 0xFF gives 256 ticks and P = 0x00 gives 65536 ticks.
- R5: De-integrate ends on the first tick that sees a high-to-low change of the synchronized comparator. `result_o` then holds the number of de-integrate ticks before that tick. A change on `cmp_i` becomes visible at clock edges at least three edges after it is driven, through a two-flop synchronizer.
- R6: Integrator-zero holds while the synchronized comparator is low. The block moves to auto-zero on the first tick that sees it high.
- R7: While `conv_hold_i` is high, the phase is auto-zero from the next clock on, and the latched result is unchanged. After release, the sequence resumes with a full auto-zero.
- R8: `dv_n_o` is low exactly while the phase is auto-zero. When it falls after a conversion, `result_o`, `ovr_o` and `pol_o` already hold that conversion's values.
- R9: After reset the phase is integrator-zero, `dv_n_o` is 1, and `result_o`, `ovr_o` and `pol_o` are 0. The phase stays at integrator-zero, even with the comparator high, until a hold or a load strobe.
- R10: On the clock where `load_n_i` is seen rising, `preload_i` is captured and the phase becomes auto-zero at the next clock. Later changes of `preload_i` have no effect on the following phase lengths.
- R11: If de-integrate reaches 2^CNT_W ticks with no comparator fall, the block sets `ovr_o`, sets `result_o` to all ones and moves to integrator-zero. A normally ended conversion clears `ovr_o`.
- R12: `pol_o` is the synchronized comparator level on the last integrate tick, where 1 means a positive input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; ticks are derived from it |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_i | input | 1 | Zero-crossing comparator from the converter (asynchronous) |
| conv_hold_i | input | 1 | High suspends conversion and holds auto-zero |
| load_n_i | input | 1 | Active-low load strobe; its rising edge applies the preload and restarts |
| preload_i | input | CNT_W-LOW_W | Preload byte that sets the auto-zero and integrate length |
| phase_o | output | 2 | Phase code to the converter |
| result_o | output | CNT_W | Latched de-integrate tick count |
| ovr_o | output | 1 | Overrange flag of the latched result |
| pol_o | output | 1 | Polarity flag of the latched result |
| dv_n_o | output | 1 | Active-low data valid, low during auto-zero |

## Verification
The assertions assume that `conv_hold_i`, `load_n_i` and `preload_i` are synchronous to `clk` and that only `cmp_i` is asynchronous. They reason about the comparator through its synchronized copy, never the raw pin. The bench drives every input on the falling clock edge, so all inputs are clean with respect to the sampling edge. The bench moves the comparator high before integrator-zero ends and low only to terminate de-integrate, the way a real converter would. That keeps the observed phase order inside the legal cycle that the order assertions expect. Preload values stay in the upper part of the range, with one directed smallest-byte case. The bench is built with a 12-bit counter so that the longest phases and the overrange run fit the run length.

// File: rtl/dss_pkg.sv
// Shared types of the dual-slope phase sequencer.
// Assumes: the phase encoding is decoded directly by the external converter.
package dss_pkg;
    typedef enum logic [1:0] {
        PH_IZ    = 2'b00,
        PH_AZ    = 2'b01,
        PH_INT   = 2'b10,
        PH_DEINT = 2'b11
    } phase_t;
endpackage

// File: rtl/dss_tick_gen.sv
// Tick generator: one-clock enable pulse every DIV clocks.
// Assumes: DIV >= 2; the counter runs freely from reset.
module dss_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_cnt;

    // Wrap the divider count at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)                div_cnt <= '0;
        else if (div_cnt == LAST)  div_cnt <= '0;
        else                       div_cnt <= div_cnt + 1'b1;
    end

    assign tick_o = (div_cnt == LAST);
endmodule

// File: rtl/dss_cmp_sync.sv
// Comparator front end: multi-flop synchronizer plus a tick-sampled
// history bit for falling-edge detection at tick rate.
// Assumes: STAGES >= 2; edges are only meaningful when tick_i is high.
module dss_cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic cmp_i,
    output logic level_o,
    output logic fall_o
);
    logic [STAGES-1:0] sync_sr;
    logic              last_tick_lvl;

    // Shift the raw comparator through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_sr <= '0;
        else        sync_sr <= {sync_sr[STAGES-2:0], cmp_i};
    end

    assign level_o = sync_sr[STAGES-1];

    // Remember the synchronized level seen at the previous tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_tick_lvl <= 1'b0;
        else if (tick_i) last_tick_lvl <= level_o;
    end

    assign fall_o = last_tick_lvl & ~level_o;
endmodule

// File: rtl/dss_phase_seq.sv
// Dual-slope converter phase sequencer (top).
// Drives the four-phase cycle, times auto-zero/integrate from a preload,
// measures de-integrate in ticks and latches result, overrange, polarity.
// Assumes: conv_hold_i, load_n_i, preload_i synchronous to clk; cmp_i async.
module dss_phase_seq
    import dss_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int LOW_W       = 8,
    parameter int DIV         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmp_i,
    input  logic                     conv_hold_i,
    input  logic                     load_n_i,
    input  logic [CNT_W-LOW_W-1:0]   preload_i,
    output logic [1:0]               phase_o,
    output logic [CNT_W-1:0]         result_o,
    output logic                     ovr_o,
    output logic                     pol_o,
    output logic                     dv_n_o
);
    localparam int PRE_W = CNT_W - LOW_W;

    phase_t             phase;
    logic [CNT_W-1:0]   span_cnt;
    logic [CNT_W-1:0]   deint_cnt;
    logic [PRE_W-1:0]   pre_q;
    logic               armed;
    logic               load_q;
    logic               load_rise;
    logic               tick;
    logic               cmp_s;
    logic               cmp_fall;

    // Remaining-ticks value for a phase: preload inverted over an all-ones low part.
    function automatic logic [CNT_W-1:0] span_m1(input logic [PRE_W-1:0] b);
        return {~b, {LOW_W{1'b1}}};
    endfunction

    dss_tick_gen #(.DIV(DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    dss_cmp_sync #(.STAGES(SYNC_STAGES)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .cmp_i   (cmp_i),
        .level_o (cmp_s),
        .fall_o  (cmp_fall)
    );

    assign load_rise = ~load_q & load_n_i;

    // Track the strobe and capture the preload on its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= 1'b1;
            pre_q  <= '1;
        end else begin
            load_q <= load_n_i;
            if (load_rise) pre_q <= preload_i;
        end
    end

    // Phase state machine, span timer and de-integrate measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IZ;
            span_cnt  <= '0;
            deint_cnt <= '0;
            result_o  <= '0;
            ovr_o     <= 1'b0;
            pol_o     <= 1'b0;
            armed     <= 1'b0;
        end else if (conv_hold_i || load_rise) begin
            phase    <= PH_AZ;
            span_cnt <= span_m1(load_rise ? preload_i : pre_q);
            armed    <= 1'b1;
        end else if (tick) begin
            case (phase)
                PH_AZ: begin
                    if (span_cnt == '0) begin
                        phase    <= PH_INT;
                        span_cnt <= span_m1(pre_q);
                    end else begin
                        span_cnt <= span_cnt - 1'b1;
                    end
                end
                PH_INT: begin
                    if (span_cnt == '0) begin
                        phase     <= PH_DEINT;
                        pol_o     <= cmp_s;
                        deint_cnt <= '0;
                    end else begin
                        span_cnt <= span_cnt - 1'b1;
                    end
                end
                PH_DEINT: begin
                    if (cmp_fall) begin
                        result_o <= deint_cnt;
                        ovr_o    <= 1'b0;
                        phase    <= PH_IZ;
                    end else if (deint_cnt == '1) begin
                        result_o <= '1;
                        ovr_o    <= 1'b1;
                        phase    <= PH_IZ;
                    end else begin
                        deint_cnt <= deint_cnt + 1'b1;
                    end
                end
                PH_IZ: begin
                    if (armed && cmp_s) begin
                        phase    <= PH_AZ;
                        span_cnt <= span_m1(pre_q);
                    end
                end
            endcase
        end
    end

    assign phase_o = phase;
    assign dv_n_o  = (phase != PH_AZ);
endmodule

// File: rtl/dss_phase_seq_chk.sv
// Property checker for dss_phase_seq, attached by bind.
// Assumes: control inputs synchronous to clk; uses the synchronized comparator.
module dss_phase_seq_chk
    import dss_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       phase,
    input logic             hold,
    input logic             load_rise,
    input logic             tick,
    input logic             cmp_s,
    input logic [CNT_W-1:0] result,
    input logic             ovr,
    input logic             dv_n
);
    logic free_run;
    assign free_run = !hold && !load_rise;

    assert_az_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (free_run && phase == PH_AZ) |=> (phase == PH_AZ || phase == PH_INT));
    assert_int_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (free_run && phase == PH_INT) |=> (phase == PH_INT || phase == PH_DEINT));
    assert_deint_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (free_run && phase == PH_DEINT) |=> (phase == PH_DEINT || phase == PH_IZ));
    assert_iz_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (free_run && phase == PH_IZ) |=> (phase == PH_IZ || phase == PH_AZ));
    assert_tick_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (free_run && !tick) |=> $stable(phase));
    assert_iz_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (free_run && phase == PH_IZ && !cmp_s) |=> phase == PH_IZ);
    assert_hold_az_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (phase == PH_AZ && $stable(result)));
    assert_dv_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dv_n) |-> $stable(result));
    assert_load_az_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_rise |=> phase == PH_AZ);
    assert_ovr_sat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> result == '1);
endmodule

bind dss_phase_seq dss_phase_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase_o),
    .hold      (conv_hold_i),
    .load_rise (load_rise),
    .tick      (tick),
    .cmp_s     (cmp_s),
    .result    (result_o),
    .ovr       (ovr_o),
    .dv_n      (dv_n_o)
);

// File: tb/dss_phase_seq_tb.sv
// Self-checking bench for dss_phase_seq: directed corners plus seeded random conversions.
module dss_phase_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 12;
    localparam int LOW_W = 8;
    localparam int PRE_W = CNT_W - LOW_W;
    localparam int DIV   = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmp = 1'b1;
    logic             hold = 1'b0;
    logic             load_n = 1'b1;
    logic [PRE_W-1:0] pre = '1;
    logic [1:0]       phase;
    logic [CNT_W-1:0] result;
    logic             ovr, pol, dv_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dss_phase_seq #(.CNT_W(CNT_W), .LOW_W(LOW_W), .DIV(DIV), .SYNC_STAGES(2)) u_dut (
        .clk (clk), .rst_n (rst_n), .cmp_i (cmp), .conv_hold_i (hold),
        .load_n_i (load_n), .preload_i (pre), .phase_o (phase),
        .result_o (result), .ovr_o (ovr), .pol_o (pol), .dv_n_o (dv_n)
    );

    // Expected ticks of one auto-zero or integrate phase (R4).
    function automatic int phase_ticks(input int p);
        return ((1 << PRE_W) - p) << LOW_W;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_load(input int p);
        @(negedge clk);
        pre = p[PRE_W-1:0];
        load_n = 1'b0;
        repeat (3) @(negedge clk);
        load_n = 1'b1;
        @(negedge clk);
        chk(phase == 2'b01, "R10 strobe rise enters auto-zero", phase, 1);
        chk(dv_n == 1'b0, "R8 dv low in auto-zero", dv_n, 0);
        pre = ~p[PRE_W-1:0];  // later changes must not matter (R10)
    endtask

    // One conversion from auto-zero (or integrate) through the next auto-zero.
    task automatic run_conv(input int p, input int k, input bit pos, input bit overrange);
        int n;
        int exp_res;
        n = 0;
        while (phase == 2'b01 && n < 300000) begin @(negedge clk); n++; end
        chk(phase == 2'b10, "R1 R2 integrate code after auto-zero", phase, 2);
        if (!pos) cmp = 1'b0;
        n = 1;
        forever begin @(negedge clk); if (phase != 2'b10 || n > 300000) break; n++; end
        chk(n == phase_ticks(p) * DIV, "R3 R4 R10 integrate length", n, phase_ticks(p) * DIV);
        chk(phase == 2'b11, "R1 R2 de-integrate code", phase, 3);
        if (!pos) cmp = 1'b1;
        if (overrange) begin
            n = 1;
            forever begin @(negedge clk); if (phase != 2'b11 || n > 300000) break; n++; end
            chk(n == (1 << CNT_W) * DIV, "R11 overrange de-integrate length", n, (1 << CNT_W) * DIV);
            chk(ovr == 1'b1, "R11 overrange flag", ovr, 1);
            exp_res = (1 << CNT_W) - 1;
            chk(result == exp_res, "R11 saturated result", result, exp_res);
        end else begin
            repeat (4 * (k - 1)) @(negedge clk);
            cmp = 1'b0;
            n = 1 + 4 * (k - 1);
            forever begin @(negedge clk); if (phase != 2'b11 || n > 300000) break; n++; end
            chk(n == 4 * k, "R5 de-integrate ends on comparator fall", n, 4 * k);
            exp_res = k - 1;
            chk(result == exp_res, "R5 result count", result, exp_res);
            chk(ovr == 1'b0, "R11 overrange cleared", ovr, 0);
        end
        chk(pol == pos, "R12 polarity", pol, pos);
        chk(phase == 2'b00, "R1 R2 integrator-zero after de-integrate", phase, 0);
        chk(dv_n == 1'b1, "R8 dv high outside auto-zero", dv_n, 1);
        cmp = 1'b0;
        repeat (2 + $urandom % 40) @(negedge clk);
        chk(phase == 2'b00, "R6 integrator-zero holds while comparator low", phase, 0);
        cmp = 1'b1;
        n = 0;
        while (phase == 2'b00 && n < 20) begin @(negedge clk); n++; end
        chk(phase == 2'b01, "R6 R2 auto-zero after comparator high", phase, 1);
        chk(dv_n == 1'b0, "R8 dv falls in auto-zero", dv_n, 0);
        chk(result == exp_res, "R8 result ready when dv falls", result, exp_res);
        n = 1;
        forever begin @(negedge clk); if (phase != 2'b01 || n > 300000) break; n++; end
        chk(n == phase_ticks(p) * DIV, "R4 auto-zero length", n, phase_ticks(p) * DIV);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        int held;
        seed_dummy = $urandom(32'd5150);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(phase == 2'b00, "R9 reset phase", phase, 0);
        chk(dv_n == 1'b1, "R9 reset dv", dv_n, 1);
        chk(result == 0, "R9 reset result", result, 0);
        chk(ovr == 1'b0 && pol == 1'b0, "R9 reset flags", {ovr, pol}, 0);
        repeat (200) @(negedge clk);
        chk(phase == 2'b00, "R9 stays idle with comparator high", phase, 0);

        do_load(15);
        run_conv(15, 1, 1'b1, 1'b0);           // shortest de-integrate
        run_conv(15, 2 + $urandom % 200, 1'b0, 1'b0);

        // Forced auto-zero during integrate (R7).
        @(negedge clk);
        held = result;
        hold = 1'b1;
        @(negedge clk);
        chk(phase == 2'b01, "R7 hold forces auto-zero", phase, 1);
        chk(dv_n == 1'b0, "R8 R7 dv low when forced", dv_n, 0);
        repeat (5 + $urandom % 16) @(negedge clk);
        chk(phase == 2'b01, "R7 auto-zero while held", phase, 1);
        chk(result == held, "R7 result unchanged while held", result, held);
        hold = 1'b0;
        run_conv(15, 2 + $urandom % 200, 1'b1, 1'b0);

        run_conv(15, 0, 1'b1, 1'b1);           // overrange
        run_conv(15, 3, 1'b1, 1'b0);           // clears overrange

        for (int i = 0; i < 4; i++) begin
            int p;
            p = 12 + $urandom % 4;
            do_load(p);
            run_conv(p, 2 + $urandom % 300, 1'($urandom % 2), 1'b0);
        end

        do_load(0);                             // longest phases
        run_conv(0, 3, 1'b1, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule